// File: doc/BRIEF.md
# Cascaded Second-Level Interrupt Aggregator

This block gathers up to 32 interrupt source lines into a second-level controller that sits below a parent interrupt controller. Each source that is not forwarded passes through a two-flop synchronizer. It is then held in a pending (status) word and gated by an enable word. The enabled, pending sources are combined into a small set of parent interrupt lines. Each parent line has its own group mask, fixed when the block is built, and it asserts when any source in its group is both pending and enabled.

A forward mask, also fixed at build time, picks sources that skip this path. Such a source drives its own parent line straight from its synchronizer, without any enable or status state in between. This suits sources such as serial ports, which the parent controller handles directly. An optional wake request is raised while any enabled source is pending.

Software reaches the block through an 8-byte register window. The window holds one enable word and one status word, and there are no atomic set or clear aliases. Bit positions that are neither in a group nor forwarded do not exist: they read as zero and never cause an output.

Top module: `irq_l2_agg`

## Requirements
- R1: After reset, the enable word, the status word, all group outputs, all forward outputs and the wake output are zero.
- R2: A write of a full 32-bit word to byte offset 0x0 replaces the enable word. A read at 0x0 returns it masked to the connected bits; with the default masks these are bits 3 to 11 (0x0000_0FF8). Software changes the enable word only by read-modify-write.
- R3: The status word is read at byte offset 0x4. A bit is set in every cycle in which its synchronized, connected, non-forwarded source is high, whatever its enable bit holds. The bit is set on the third rising clock edge after the source rises.
- R4: Writing to offset 0x4 clears every status bit that is 1 in the written data. Bits written as 0 keep their value. A cleared bit whose source is still high reads 1 again one cycle later.
- R5: Group output k is registered and equals the OR of (status AND enable AND group mask k) one clock earlier. It therefore asserts on the fourth rising edge after a source rises.
- R6: With the default parameters, grp_irq_o[0] uses group mask 0x0000_0EB8 (sources 3, 4, 5, 7, 9, 10, 11) and grp_irq_o[1] uses group mask 0x0000_0140 (sources 6 and 8).
- R7: Each source whose forward bit is set (default mask 0x7, sources 0 to 2) appears on fwd_irq_o at its own bit position two rising edges after it changes. It never sets a status bit and never affects a group output or the wake output.
- R8: Bits of fwd_irq_o whose forward bit is clear are always 0.
- R9: When WAKE_EN is 1, wake_o is registered and equals the OR of (status AND enable) over all bits one clock earlier.
- R10: A source at an unconnected position (default bits 12 to 31) never sets status and never asserts any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Asynchronous interrupt source lines |
| reg_wr_i | input | 1 | Register write strobe (word-aligned addresses only) |
| reg_addr_i | input | 3 | Byte address in the window: 0x0 enable, 0x4 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| grp_irq_o | output | NOUT | Gated group interrupt lines to the parent |
| fwd_irq_o | output | 32 | Forwarded per-source lines to the parent |
| wake_o | output | 1 | Wake request |

## Verification
The bench drives a table of source and enable patterns. The table includes a source held pending while its enable bit is clear, which a design that gates status with enable would show as a status bit of zero. It also drives the unconnected high bits, which a design without the connected-bit mask would show as set status bits or a stray group line. The bench counts edges from a source rising to status, to the group line and to the forward line. A design with a missing or extra register stage would show its output one cycle early or late. A clear written while the source is still high must be followed by the bit setting again one cycle later, and bits written as 0 must survive. A design that lets a forwarded source reach status would show a nonzero status readback while only sources 0 to 2 are driven.

// File: rtl/irq_l2_pkg.sv
`timescale 1ns/1ps
package irq_l2_pkg;
    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Register state of the aggregator
    typedef struct packed {
        word_t enable;
        word_t status;
    } regs_t;

    // Two synchronizer stages
    typedef struct packed {
        word_t s1;
        word_t s2;
    } sync_t;
endpackage

// File: rtl/irq_l2_sync.sv
`timescale 1ns/1ps
module irq_l2_sync
    import irq_l2_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  word_t async_i,
    output word_t sync_o
);
    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/irq_l2_regs.sv
`timescale 1ns/1ps
module irq_l2_regs
    import irq_l2_pkg::*;
#(
    parameter word_t CONN_MASK = 32'h0000_0FF8
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  word_t src_sync_i,
    input  logic  wr_i,
    input  logic  sel_status_i,
    input  word_t wdata_i,
    output word_t enable_o,
    output word_t status_o,
    output word_t rdata_o
);
    regs_t r_d, r_q;
    word_t clr_mask;

    always_comb begin
        r_d      = r_q;
        clr_mask = '0;
        if (wr_i && !sel_status_i) r_d.enable = wdata_i & CONN_MASK;
        if (wr_i &&  sel_status_i) clr_mask   = wdata_i;
        r_d.status = (r_q.status | (src_sync_i & CONN_MASK)) & ~clr_mask;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign enable_o = r_q.enable;
    assign status_o = r_q.status;
    assign rdata_o  = sel_status_i ? r_q.status : r_q.enable;
endmodule

// File: rtl/irq_l2_route.sv
`timescale 1ns/1ps
module irq_l2_route
    import irq_l2_pkg::*;
#(
    parameter int                      NOUT       = 2,
    parameter logic [NOUT-1:0][WORD_W-1:0] GROUP_MASK = {32'h0000_0140, 32'h0000_0EB8},
    parameter bit                      WAKE_EN    = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  word_t           status_i,
    input  word_t           enable_i,
    output logic [NOUT-1:0] grp_o,
    output logic            wake_o
);
    typedef struct packed {
        logic [NOUT-1:0] grp;
        logic            wake;
    } out_t;

    out_t o_d, o_q;
    word_t live;

    always_comb begin
        live = status_i & enable_i;
        o_d  = o_q;
        for (int k = 0; k < NOUT; k++) begin
            o_d.grp[k] = |(live & GROUP_MASK[k]);
        end
        o_d.wake = 1'b0;
        if (WAKE_EN) o_d.wake = |live;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) o_q <= '0;
        else         o_q <= o_d;
    end

    assign grp_o  = o_q.grp;
    assign wake_o = o_q.wake;
endmodule

// File: rtl/irq_l2_agg.sv
`timescale 1ns/1ps
module irq_l2_agg
    import irq_l2_pkg::*;
#(
    parameter int                      NOUT       = 2,
    parameter logic [NOUT-1:0][WORD_W-1:0] GROUP_MASK = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [WORD_W-1:0]       FWD_MASK   = 32'h0000_0007,
    parameter bit                      WAKE_EN    = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [31:0]      src_i,
    input  logic             reg_wr_i,
    input  logic [2:0]       reg_addr_i,
    input  logic [31:0]      reg_wdata_i,
    output logic [31:0]      reg_rdata_o,
    output logic [NOUT-1:0]  grp_irq_o,
    output logic [31:0]      fwd_irq_o,
    output logic             wake_o
);
    function automatic word_t conn_mask_f();
        word_t m = '0;
        for (int k = 0; k < NOUT; k++) m = m | GROUP_MASK[k];
        return m & ~FWD_MASK;
    endfunction

    localparam word_t CONN_MASK = conn_mask_f();

    word_t src_sync;
    word_t enable_w;
    word_t status_w;
    logic  wr_ok;

    // Only word-aligned accesses reach the registers
    assign wr_ok = reg_wr_i && (reg_addr_i[1:0] == 2'b00);

    irq_l2_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(src_i),
        .sync_o (src_sync)
    );

    irq_l2_regs #(.CONN_MASK(CONN_MASK)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .src_sync_i  (src_sync),
        .wr_i        (wr_ok),
        .sel_status_i(reg_addr_i[2]),
        .wdata_i     (reg_wdata_i),
        .enable_o    (enable_w),
        .status_o    (status_w),
        .rdata_o     (reg_rdata_o)
    );

    irq_l2_route #(
        .NOUT      (NOUT),
        .GROUP_MASK(GROUP_MASK),
        .WAKE_EN   (WAKE_EN)
    ) u_route (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .status_i(status_w),
        .enable_i(enable_w),
        .grp_o   (grp_irq_o),
        .wake_o  (wake_o)
    );

    // Bypass muxes: a forwarded source goes straight from its synchronizer
    for (genvar i = 0; i < WORD_W; i++) begin : g_fwd
        if (FWD_MASK[i]) begin : g_on
            assign fwd_irq_o[i] = src_sync[i];
        end else begin : g_off
            assign fwd_irq_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_l2_agg_chk.sv
`timescale 1ns/1ps
module irq_l2_agg_chk
    import irq_l2_pkg::*;
#(
    parameter int                      NOUT       = 2,
    parameter logic [NOUT-1:0][WORD_W-1:0] GROUP_MASK = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [WORD_W-1:0]       FWD_MASK   = 32'h0000_0007,
    parameter word_t                   CONN_MASK  = 32'h0000_0FF8,
    parameter bit                      WAKE_EN    = 1'b1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            reg_wr_i,
    input logic [2:0]      reg_addr_i,
    input logic [31:0]     reg_wdata_i,
    input logic [31:0]     reg_rdata_o,
    input logic [NOUT-1:0] grp_irq_o,
    input logic [31:0]     fwd_irq_o,
    input logic            wake_o,
    input word_t           enable_q,
    input word_t           status_q
);
    AST_ENABLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 3'd0) |=> (enable_q == ($past(reg_wdata_i) & CONN_MASK))); // R2

    AST_READ_CONNECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rdata_o & ~CONN_MASK) == '0); // R10

    AST_STATUS_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 3'd4) |=> ((status_q & $past(reg_wdata_i)) == '0)); // R4

    AST_FWD_UNUSED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fwd_irq_o & ~FWD_MASK) == '0); // R8

    for (genvar k = 0; k < NOUT; k++) begin : g_grp
        AST_GROUP_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            grp_irq_o[k] == $past(|(status_q & enable_q & GROUP_MASK[k]))); // R5
    end

    if (WAKE_EN) begin : g_wake
        AST_WAKE_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wake_o == $past(|(status_q & enable_q))); // R9
    end
endmodule

bind irq_l2_agg irq_l2_agg_chk #(
    .NOUT      (NOUT),
    .GROUP_MASK(GROUP_MASK),
    .FWD_MASK  (FWD_MASK),
    .CONN_MASK (CONN_MASK),
    .WAKE_EN   (WAKE_EN)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .grp_irq_o  (grp_irq_o),
    .fwd_irq_o  (fwd_irq_o),
    .wake_o     (wake_o),
    .enable_q   (enable_w),
    .status_q   (status_w)
);

// File: tb/irq_l2_agg_bench.sv
`timescale 1ns/1ps
module irq_l2_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  grp;
    logic [31:0] fwd;
    logic        wake;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_l2_agg u_irq_l2_agg (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .grp_irq_o(grp), .fwd_irq_o(fwd), .wake_o(wake)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] en;
        logic [31:0] st;
        logic [1:0]  grp;
        logic        wake;
    } vec_t;

    // grp[0]: mask 0xEB8, grp[1]: mask 0x140; connected bits 0xFF8
    localparam vec_t VECS [0:6] = '{
        '{32'h0000_0008, 32'h0000_0FFF, 32'h0000_0008, 2'b01, 1'b1},
        '{32'h0000_0040, 32'h0000_0FFF, 32'h0000_0040, 2'b10, 1'b1},
        '{32'h0000_0140, 32'h0000_0100, 32'h0000_0140, 2'b10, 1'b1},
        '{32'h0000_00B8, 32'h0000_0000, 32'h0000_00B8, 2'b00, 1'b0},
        '{32'hFFFF_F000, 32'hFFFF_FFFF, 32'h0000_0000, 2'b00, 1'b0},
        '{32'h0000_0007, 32'h0000_0FFF, 32'h0000_0000, 2'b00, 1'b0},
        '{32'h0000_0E00, 32'h0000_0600, 32'h0000_0E00, 2'b01, 1'b1}
    };

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        @(negedge clk);
        tick(3);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(3'd0, rd); check(rd == 0, "R1 enable", rd, 0);
        reg_read(3'd4, rd); check(rd == 0, "R1 status", rd, 0);
        check({grp, wake} == 0 && fwd == 0, "R1 outputs", {grp, wake}, 0);

        // R2 enable write and masked readback
        reg_write(3'd0, 32'hFFFF_FFFF);
        reg_read(3'd0, rd); check(rd == 32'h0000_0FF8, "R2 enable readback", rd, 32'h0FF8);

        // Table walk: R3 R5 R6 R7 R9 R10
        foreach (VECS[i]) begin
            src = '0;
            tick(4);
            reg_write(3'd4, 32'hFFFF_FFFF);
            reg_write(3'd0, VECS[i].en);
            src = VECS[i].src;
            tick(5);
            reg_read(3'd4, rd);
            check(rd == VECS[i].st, $sformatf("R3 R10 status vec%0d", i), rd, VECS[i].st);
            check(grp == VECS[i].grp, $sformatf("R5 R6 grp vec%0d", i), {30'd0, grp}, {30'd0, VECS[i].grp});
            check(wake == VECS[i].wake, $sformatf("R9 wake vec%0d", i), {31'd0, wake}, {31'd0, VECS[i].wake});
            check(fwd == (VECS[i].src & 32'h7), $sformatf("R7 R8 fwd vec%0d", i), fwd, VECS[i].src & 32'h7);
        end

        // Latency: R3 R5 R7
        src = '0;
        tick(4);
        reg_write(3'd4, 32'hFFFF_FFFF);
        reg_write(3'd0, 32'h0000_0FFF);
        tick(2);
        src = 32'h0000_0009;
        tick();
        check(fwd[0] == 1'b0, "R7 fwd not after one edge", fwd, 0);
        tick();
        check(fwd[0] == 1'b1, "R7 fwd after two edges", fwd, 1);
        reg_read(3'd4, rd); check(rd == 0, "R3 status not after two edges", rd, 0);
        tick();
        reg_read(3'd4, rd); check(rd == 32'h8, "R3 status after three edges", rd, 32'h8);
        check(grp[0] == 1'b0, "R5 grp not after three edges", {30'd0, grp}, 0);
        tick();
        check(grp[0] == 1'b1, "R5 grp after four edges", {30'd0, grp}, 1);

        // R4 clear while source held, then re-latch
        reg_write(3'd4, 32'h0000_0008);
        reg_read(3'd4, rd); check(rd == 0, "R4 cleared", rd, 0);
        tick();
        reg_read(3'd4, rd); check(rd == 32'h8, "R4 re-latch", rd, 32'h8);

        // R4 zero bits keep their value
        src = 32'h0000_0048;
        tick(4);
        reg_write(3'd4, 32'h0000_0040);
        reg_read(3'd4, rd); check(rd == 32'h8, "R4 partial clear", rd, 32'h8);

        // R10 only unconnected sources keep all outputs low
        src = '0;
        tick(4);
        reg_write(3'd4, 32'hFFFF_FFFF);
        src = 32'hFFFF_F000;
        tick(6);
        check({grp, wake} == 0 && fwd == 0, "R10 no output", {grp, wake}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule